// File: doc/BRIEF.md
# Startup and auto-restart supervisor

This block is the sequencing controller of an offline switching converter. It watches a set of clean digital comparator flags (high-voltage input present, supply at turn-on level, supply under the undervoltage level, supply under the restart level, feedback overload, brownout low and high, brownout disable, thermal trip and release) together with an already qualified fault flag. From these it decides when the high-voltage startup current source charges the supply capacitor, which of the two charge-current levels that source uses, when the power switch may operate, and the soft-start value that scales the cycle-by-cycle current limit.

A normal start charges with the full current until the supply reaches turn-on, then switches with a current limit that rises from zero to full scale over the soft-start time. After an overload or any other fault, switching stops, the reduced charge current is selected, and the supply is left to discharge through the undervoltage level and down to the low restart level before the capacitor is charged again. This gives slow hiccup retries. Brownout and thermal shutdown only pause switching. When either is released, a fresh soft-start follows.

Top module: `supv_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `hvEn`, `swEn` and `chargeLow` are 0 and `ssRamp` is 0.
- R2: `hvEn` is 1 only in the charging phase and only while `hvOk` is 1. From power-off, `hvOk` high starts charging one cycle later. Losing `hvOk` while charging returns the block to power-off.
- R3: `chargeLow` selects the charge current: 0 means the normal (full) current and 1 means the reduced fault current. It rises only on a cycle that follows `fbOvl` or `faultIn` high.
- R4: While charging, `vddOn` high causes the following on the next cycle: `swEn` is 1, `hvEn` is 0 and `ssRamp` is 0.
- R5: During unheld soft-start, `ssRamp` increases by one every STEP_CYC cycles, where STEP_CYC = CLK_KHZ*SS_US/1000/(2^RAMP_W-1). It saturates at 2^RAMP_W-1, and the block then enters normal run.
- R6: With `brDis` at 0, `brLow` drops `swEn` to 0 one cycle later. Switching stays off until `brHigh` is seen, even if `brLow` has already fallen. `ssRamp` restarts from 0.
- R7: While `brDis` is 1, `brLow` has no effect on `swEn`.
- R8: `fbOvl` or `faultIn` during soft-start or run drives `swEn` to 0 and `chargeLow` to 1 on the next cycle.
- R9: After a fault stop, `hvEn` stays 0 until `vddUv` has been seen and then `vddRst` is seen.
- R10: When `vddRst` is seen in the restart wait, the block returns to charging if `hvOk` is 1. Otherwise power-down completes and `hvEn` stays 0 while `hvOk` stays 0.
- R11: `chargeLow` returns to 0 when a soft-start completes, that is, when the ramp reaches full scale.
- R12: `tsdTrip` drops `swEn` to 0 one cycle later and it stays 0 until `tsdRelease`. Switching then resumes with `ssRamp` at 0.
- R13: `vddUv` during soft-start or run stops switching on the next cycle without setting `chargeLow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hvOk | input | 1 | Rectified input above the startup threshold |
| vddOn | input | 1 | Supply at or above the turn-on threshold |
| vddUv | input | 1 | Supply below the undervoltage threshold |
| vddRst | input | 1 | Supply below the restart threshold |
| fbOvl | input | 1 | Feedback above the overload threshold |
| faultIn | input | 1 | Qualified fault latches (overvoltage, second overcurrent) |
| brLow | input | 1 | Brownout pin below its falling threshold |
| brHigh | input | 1 | Brownout pin above threshold plus hysteresis |
| brDis | input | 1 | Brownout pin held below the disable level |
| tsdTrip | input | 1 | Junction temperature at the shutdown level |
| tsdRelease | input | 1 | Junction temperature below the release level |
| hvEn | output | 1 | Startup current source enable |
| chargeLow | output | 1 | Reduced charge current select |
| swEn | output | 1 | Power switch enable |
| ssRamp | output | RAMP_W | Soft-start current-limit scale |

## Verification
The assertions assume that the comparator flags are settled digital levels that describe a physically consistent supply. `vddOn` is never high together with `vddUv`, and `vddRst` is only raised while `vddUv` is also high. The stimulus changes flags half a cycle away from the clock edge and pulses one event at a time. It also returns the supply flags to a consistent set before each new phase, so no check relies on two simultaneous events whose order the requirements leave open.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [2:0] {
    ST_OFF            = 3'd0,
    ST_CHARGE         = 3'd1,
    ST_SOFTSTART      = 3'd2,
    ST_RUN            = 3'd3,
    ST_STOP_WAIT_UVLO = 3'd4,
    ST_WAIT_RESTART   = 3'd5
  } supvState_t;

  // strobes from control to the ramp datapath
  typedef struct packed {
    logic rampClr;
    logic rampRun;
  } rampCmd_t;

endpackage

// File: rtl/supv_ramp.sv
module supv_ramp
  import supv_pkg::*;
#(
  parameter int RAMP_W   = 8,
  parameter int STEP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  rampCmd_t          cmd,
  output logic [RAMP_W-1:0] ramp,
  output logic              rampFull
);

  localparam int DIV_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(STEP_CYC - 1);
  localparam logic [RAMP_W-1:0] RAMP_MAX = {RAMP_W{1'b1}};

  logic [DIV_W-1:0]  divCnt;
  logic [RAMP_W-1:0] rampQ;

  always_ff @(posedge clk) begin
    if (rst || cmd.rampClr) begin
      divCnt <= '0;
      rampQ  <= '0;
    end else if (cmd.rampRun && (rampQ != RAMP_MAX)) begin
      if (divCnt == DIV_LAST) begin
        divCnt <= '0;
        rampQ  <= rampQ + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign ramp     = rampQ;
  assign rampFull = (rampQ == RAMP_MAX);

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hvOk,
  input  logic     vddOn,
  input  logic     vddUv,
  input  logic     vddRst,
  input  logic     fbOvl,
  input  logic     faultIn,
  input  logic     brLow,
  input  logic     brHigh,
  input  logic     brDis,
  input  logic     tsdTrip,
  input  logic     tsdRelease,
  input  logic     rampFull,
  output rampCmd_t cmd,
  output logic     hvEn,
  output logic     chargeLow,
  output logic     swEn
);

  supvState_t stateQ, stateNext;
  logic brActive, tsdHot, faultSticky;
  logic hold, fault, active;

  // brownout: non-latched, hysteretic, overridden by the disable flag
  always_ff @(posedge clk) begin
    if (rst || brDis) brActive <= 1'b0;
    else if (brLow)   brActive <= 1'b1;
    else if (brHigh)  brActive <= 1'b0;
  end

  // thermal: trip and separate release flag
  always_ff @(posedge clk) begin
    if (rst)             tsdHot <= 1'b0;
    else if (tsdTrip)    tsdHot <= 1'b1;
    else if (tsdRelease) tsdHot <= 1'b0;
  end

  assign hold   = brActive | tsdHot;
  assign fault  = fbOvl | faultIn;
  assign active = (stateQ == ST_SOFTSTART) || (stateQ == ST_RUN);

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_OFF:       if (hvOk) stateNext = ST_CHARGE;
      ST_CHARGE: begin
        if (!hvOk)      stateNext = ST_OFF;
        else if (vddOn) stateNext = ST_SOFTSTART;
      end
      ST_SOFTSTART: begin
        if (vddUv)                  stateNext = ST_WAIT_RESTART;
        else if (fault)             stateNext = ST_STOP_WAIT_UVLO;
        else if (!hold && rampFull) stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (vddUv)      stateNext = ST_WAIT_RESTART;
        else if (fault) stateNext = ST_STOP_WAIT_UVLO;
        else if (hold)  stateNext = ST_SOFTSTART;
      end
      ST_STOP_WAIT_UVLO: if (vddUv) stateNext = ST_WAIT_RESTART;
      ST_WAIT_RESTART:
        if (vddRst) stateNext = hvOk ? ST_CHARGE : ST_OFF;
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_OFF;
    else     stateQ <= stateNext;
  end

  // sticky fault: set on entering the fault stop, cleared by a finished soft-start
  always_ff @(posedge clk) begin
    if (rst)
      faultSticky <= 1'b0;
    else if (stateNext == ST_STOP_WAIT_UVLO && stateQ != ST_STOP_WAIT_UVLO)
      faultSticky <= 1'b1;
    else if (stateQ == ST_SOFTSTART && stateNext == ST_RUN)
      faultSticky <= 1'b0;
  end

  assign cmd.rampClr = !active || hold;
  assign cmd.rampRun = (stateQ == ST_SOFTSTART) && !hold;

  assign hvEn      = (stateQ == ST_CHARGE) && hvOk;
  assign chargeLow = faultSticky;
  assign swEn      = active && !hold;

endmodule

// File: rtl/supv_top.sv
module supv_top
  import supv_pkg::*;
#(
  parameter int CLK_KHZ = 200000,
  parameter int SS_US   = 8500,
  parameter int RAMP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hvOk,
  input  logic              vddOn,
  input  logic              vddUv,
  input  logic              vddRst,
  input  logic              fbOvl,
  input  logic              faultIn,
  input  logic              brLow,
  input  logic              brHigh,
  input  logic              brDis,
  input  logic              tsdTrip,
  input  logic              tsdRelease,
  output logic              hvEn,
  output logic              chargeLow,
  output logic              swEn,
  output logic [RAMP_W-1:0] ssRamp
);

  localparam int RAMP_STEPS = (1 << RAMP_W) - 1;
  localparam int STEP_RAW   = CLK_KHZ * SS_US / 1000 / RAMP_STEPS;
  localparam int STEP_CYC   = (STEP_RAW > 0) ? STEP_RAW : 1;

  rampCmd_t rampCmd;
  logic     rampFull;

  supv_ctrl u_ctrl (
    .clk(clk), .rst(rst), .hvOk(hvOk), .vddOn(vddOn), .vddUv(vddUv),
    .vddRst(vddRst), .fbOvl(fbOvl), .faultIn(faultIn), .brLow(brLow),
    .brHigh(brHigh), .brDis(brDis), .tsdTrip(tsdTrip),
    .tsdRelease(tsdRelease), .rampFull(rampFull), .cmd(rampCmd),
    .hvEn(hvEn), .chargeLow(chargeLow), .swEn(swEn)
  );

  supv_ramp #(.RAMP_W(RAMP_W), .STEP_CYC(STEP_CYC)) u_ramp (
    .clk(clk), .rst(rst), .cmd(rampCmd), .ramp(ssRamp), .rampFull(rampFull)
  );

endmodule

// File: rtl/supv_chk.sv
module supv_chk #(
  parameter int RAMP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              hvOk,
  input logic              vddUv,
  input logic              fbOvl,
  input logic              faultIn,
  input logic              hvEn,
  input logic              chargeLow,
  input logic              swEn,
  input logic [RAMP_W-1:0] ssRamp
);

  localparam logic [RAMP_W-1:0] FULL = {RAMP_W{1'b1}};

  p_hv_gate_r2: assert property (@(posedge clk) disable iff (rst)
    hvEn |-> hvOk);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(hvEn && swEn));

  p_ramp_step_r5: assert property (@(posedge clk) disable iff (rst)
    (ssRamp != $past(ssRamp)) |-> (ssRamp == $past(ssRamp) + 1'b1 || ssRamp == '0));

  p_fault_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (swEn && (fbOvl || faultIn) && !vddUv) |=> (!swEn && chargeLow));

  p_sticky_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(chargeLow) |-> $past(fbOvl || faultIn));

  p_sticky_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(chargeLow) |-> (ssRamp == FULL));

  p_uv_stop_r13: assert property (@(posedge clk) disable iff (rst)
    (swEn && vddUv) |=> !swEn);

endmodule

bind supv_top supv_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst(rst), .hvOk(hvOk), .vddUv(vddUv), .fbOvl(fbOvl),
  .faultIn(faultIn), .hvEn(hvEn), .chargeLow(chargeLow), .swEn(swEn),
  .ssRamp(ssRamp)
);

// File: tb/test_supv_top.sv
module test_supv_top;

  localparam int RAMP_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hvOk = 0, vddOn = 0, vddUv = 0, vddRst = 0, fbOvl = 0, faultIn = 0;
  logic brLow = 0, brHigh = 0, brDis = 0, tsdTrip = 0, tsdRelease = 0;
  logic hvEn, chargeLow, swEn;
  logic [RAMP_W-1:0] ssRamp;

  always #2.5 clk = ~clk;

  // 1 MHz nominal and 1020 us give 4 cycles per ramp step
  supv_top #(.CLK_KHZ(1000), .SS_US(1020), .RAMP_W(RAMP_W)) i_supv_top (
    .clk(clk), .rst(rst), .hvOk(hvOk), .vddOn(vddOn), .vddUv(vddUv),
    .vddRst(vddRst), .fbOvl(fbOvl), .faultIn(faultIn), .brLow(brLow),
    .brHigh(brHigh), .brDis(brDis), .tsdTrip(tsdTrip),
    .tsdRelease(tsdRelease), .hvEn(hvEn), .chargeLow(chargeLow),
    .swEn(swEn), .ssRamp(ssRamp)
  );

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  function automatic int pick(int sel);
    case (sel)
      0: return int'(hvEn);
      1: return int'(swEn);
      2: return int'(chargeLow);
      default: return int'(ssRamp);
    endcase
  endfunction

  // monitor: scoreboard compare away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it  = q.pop_front();
      act = pick(it.sel);
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_v(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic fin();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    expect_v("R1", 0, 0); expect_v("R1", 1, 0); expect_v("R1", 2, 0); expect_v("R1", 3, 0);
    fin();
    rst = 0;
    cyc(1);
    expect_v("R1", 0, 0); expect_v("R1", 1, 0); expect_v("R1", 3, 0);
    fin();

    // R2: charge on input present, drop out on loss
    hvOk = 1; cyc(1);
    expect_v("R2", 0, 1); expect_v("R3", 2, 0); fin();
    hvOk = 0; cyc(1);
    expect_v("R2", 0, 0); fin();
    hvOk = 1; cyc(1);
    expect_v("R2", 0, 1); fin();

    // R4: turn-on
    vddOn = 1; cyc(1);
    expect_v("R4", 1, 1); expect_v("R4", 0, 0); expect_v("R4", 3, 0); fin();
    vddOn = 0;

    // R5: ramp step
    cyc(42);
    expect_v("R5", 3, 10); fin();

    // R6: brownout hysteresis
    brLow = 1; cyc(1);
    expect_v("R6", 1, 0); fin();
    cyc(1);
    expect_v("R6", 3, 0); fin();
    brLow = 0; cyc(3);
    expect_v("R6", 1, 0); fin();
    brHigh = 1; cyc(1);
    expect_v("R6", 1, 1); expect_v("R6", 3, 0); fin();
    brHigh = 0;

    // R7: brownout disabled
    brDis = 1; brLow = 1; cyc(3);
    expect_v("R7", 1, 1); fin();
    brDis = 0; brLow = 0;

    // R5: saturation
    cyc(1100);
    expect_v("R5", 3, 255); expect_v("R5", 1, 1); fin();

    // R8: overload
    fbOvl = 1; cyc(1);
    expect_v("R8", 1, 0); expect_v("R8", 2, 1); fin();
    fbOvl = 0; cyc(1);
    expect_v("R8", 3, 0); fin();

    // R9: wait for undervoltage then restart level
    vddUv = 1; cyc(1);
    expect_v("R9", 0, 0); fin();
    cyc(5);
    expect_v("R9", 0, 0); fin();
    vddRst = 1; cyc(1);
    expect_v("R10", 0, 1); expect_v("R3", 2, 1); fin();
    vddUv = 0; vddRst = 0;

    // R11: clean soft-start clears the reduced current
    vddOn = 1; cyc(1);
    expect_v("R11", 1, 1); expect_v("R11", 2, 1); fin();
    vddOn = 0; cyc(1100);
    expect_v("R11", 3, 255); expect_v("R11", 2, 0); fin();

    // R12: thermal
    tsdTrip = 1; cyc(1);
    expect_v("R12", 1, 0); fin();
    tsdTrip = 0; cyc(3);
    expect_v("R12", 1, 0); fin();
    tsdRelease = 1; cyc(1);
    expect_v("R12", 1, 1); expect_v("R12", 3, 0); fin();
    tsdRelease = 0;

    // R13: undervoltage without fault
    vddUv = 1; cyc(1);
    expect_v("R13", 1, 0); expect_v("R13", 2, 0); fin();

    // R10: power-down completes
    hvOk = 0; vddRst = 1; cyc(1);
    expect_v("R10", 0, 0); fin();
    cyc(3);
    expect_v("R10", 0, 0); expect_v("R10", 1, 0); fin();
    vddUv = 0; vddRst = 0; hvOk = 1; cyc(1);
    expect_v("R2", 0, 1); expect_v("R3", 2, 0); fin();

    // R8: external qualified fault during soft-start
    vddOn = 1; cyc(1);
    expect_v("R4", 1, 1); fin();
    vddOn = 0; faultIn = 1; cyc(1);
    expect_v("R8", 1, 0); expect_v("R8", 2, 1); fin();
    faultIn = 0;
    cyc(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule